// File: doc/BRIEF.md
# Two-stage serial-in shift register with latched outputs

This block models two 8-bit serial-to-parallel shift registers chained back to back. Each register has its own output storage register. It runs on a fast system clock. The serial data line, the shift clock and the latch clock reach it as ordinary asynchronous inputs. All three are sampled through two-flop synchronizers. A detected rising edge of the shift clock shifts the chain by one place. A detected rising edge of the latch clock copies both shift registers into their storage registers.

A host sends a 16-bit frame most significant bit first while the latch clock is held low, then gives one positive latch pulse. The first eight bits sent appear on the segment output and the last eight on the digit-select output. Between latch pulses the outputs never move, however many bits are shifted in. An output enable blanks both outputs to all ones without losing the stored word. The serial cascade output carries the last stage's top bit, so the chain can be extended.

Top module: `cascade_sipo_latch`

## Requirements
- R1: While reset is asserted (rst_n low) and right after it is released, seg_o and dsel_o read 8'hFF and cascade_o reads 0. The shift registers clear to zero and the storage registers set to all ones.
- R2: Each rising edge of shclk_in moves every shift-register bit up one place (Q0 to Q1 and so on) and loads the synchronized ser_in into Q0 of the first stage.
- R3: seg_o and dsel_o do not change while bits are shifted and no latch edge occurs.
- R4: A rising edge of latclk_in copies the shift registers into the storage registers. For a 16-bit frame sent most significant bit first, seg_o becomes frame bits [15:8] and dsel_o becomes frame bits [7:0].
- R5: Each register acts once per rising edge, however long its clock is held high. Falling edges change nothing.
- R6: The top bit Q7 of the first stage enters Q0 of the second stage on the same shift edge, using its value from before that edge. cascade_o is the second stage's Q7, so after 16 shifts it equals the first bit sent.
- R7: With out_en low, seg_o and dsel_o read 8'hFF. The stored word is kept and reappears when out_en returns high.
- R8: A latch edge detected in the same system cycle as a shift edge captures the shift-register contents from before that shift.
- R9: A rise of latclk_in, applied between system clock edges, changes the outputs on the third rising system clock edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_in | input | 1 | Serial data line |
| shclk_in | input | 1 | Shift clock, sampled; rising edge shifts |
| latclk_in | input | 1 | Latch clock, sampled; rising edge stores |
| out_en | input | 1 | High drives the stored word; low blanks to all ones |
| seg_o | output | 8 | Segment byte (second stage storage) |
| dsel_o | output | 8 | Digit-select byte (first stage storage) |
| cascade_o | output | 1 | Serial cascade output, second stage Q7 |

## Verification
The hardest case to reach from the ports is a latch edge detected in exactly the same system cycle as a shift edge. The host clocks are asynchronous inputs, and each goes through its own synchronizer. The bench drives both clock inputs high at the same falling system edge, so both synchronizers see the rise together. It then checks that the stored word is the frame from before that shift. A second, separate latch pulse afterwards shows that the shift did happen. Holding the shift clock high for many cycles shows that one rise gives one shift.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  // Number of chained stages; the output mapping assumes exactly two.
  localparam int unsigned NUM_STAGES = 2;

  // Rising-edge test on a synchronized level and its previous sample.
  function automatic logic rise_of(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  // Output blanking for one byte: all ones when disabled.
  function automatic logic [7:0] blank_byte(input logic en, input logic [7:0] v);
    return en ? v : 8'hFF;
  endfunction
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[DEPTH-2:0], d};
  end

  assign q = pipe[DEPTH-1];
endmodule

// File: rtl/rise_detect.sv
module rise_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  import sipo_pkg::*;
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  assign rise = rise_of(lvl, prev);
endmodule

// File: rtl/sipo_stage.sv
module sipo_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sh_ev,
  input  logic         lat_ev,
  input  logic         sin,
  output logic [W-1:0] sr_q,
  output logic [W-1:0] st_q,
  output logic         sout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sh_ev) sr_q <= {sr_q[W-2:0], sin};
  end

  // Nonblocking update: a latch in a shift cycle stores the old contents.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st_q <= '1;
    else if (lat_ev) st_q <= sr_q;
  end

  assign sout = sr_q[W-1];
endmodule

// File: rtl/cascade_sipo_latch.sv
module cascade_sipo_latch #(
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_in,
  input  logic       shclk_in,
  input  logic       latclk_in,
  input  logic       out_en,
  output logic [7:0] seg_o,
  output logic [7:0] dsel_o,
  output logic       cascade_o
);
  import sipo_pkg::*;
  localparam int unsigned W  = 8;
  localparam int unsigned NS = NUM_STAGES;

  logic ser_s, sh_lvl, lat_lvl;
  logic sh_ev, lat_ev;
  logic [NS-1:0][W-1:0] sr_q;
  logic [NS-1:0][W-1:0] st_q;
  logic [NS:0]          chain;

  bit_sync #(.DEPTH(SYNC_DEPTH)) u_ser_sync (.clk(clk), .rst_n(rst_n), .d(ser_in),    .q(ser_s));
  bit_sync #(.DEPTH(SYNC_DEPTH)) u_sh_sync  (.clk(clk), .rst_n(rst_n), .d(shclk_in),  .q(sh_lvl));
  bit_sync #(.DEPTH(SYNC_DEPTH)) u_lat_sync (.clk(clk), .rst_n(rst_n), .d(latclk_in), .q(lat_lvl));

  rise_detect u_sh_rise  (.clk(clk), .rst_n(rst_n), .lvl(sh_lvl),  .rise(sh_ev));
  rise_detect u_lat_rise (.clk(clk), .rst_n(rst_n), .lvl(lat_lvl), .rise(lat_ev));

  assign chain[0] = ser_s;

  for (genvar k = 0; k < NS; k++) begin : g_stage
    sipo_stage #(.W(W)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .sh_ev  (sh_ev),
      .lat_ev (lat_ev),
      .sin    (chain[k]),
      .sr_q   (sr_q[k]),
      .st_q   (st_q[k]),
      .sout   (chain[k+1])
    );
  end

  assign seg_o     = blank_byte(out_en, st_q[NS-1]);
  assign dsel_o    = blank_byte(out_en, st_q[0]);
  assign cascade_o = chain[NS];
endmodule

// File: rtl/cascade_sipo_latch_chk.sv
module cascade_sipo_latch_chk #(
  parameter int unsigned W  = 8,
  parameter int unsigned NS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 out_en,
  input logic                 sh_ev,
  input logic                 lat_ev,
  input logic                 ser_s,
  input logic [NS-1:0][W-1:0] sr_q,
  input logic [NS-1:0][W-1:0] st_q,
  input logic [7:0]           seg_o,
  input logic [7:0]           dsel_o
);
  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    sh_ev |=> sr_q[0] == {$past(sr_q[0][W-2:0]), $past(ser_s)});

  a_r6_cascade: assert property (@(posedge clk) disable iff (!rst_n)
    sh_ev |=> sr_q[1][0] == $past(sr_q[0][W-1]));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_ev |=> $stable(st_q));

  a_r8_capture_old: assert property (@(posedge clk) disable iff (!rst_n)
    lat_ev |=> st_q == $past(sr_q));

  a_r5_single_shift: assert property (@(posedge clk) disable iff (!rst_n)
    sh_ev |=> !sh_ev);

  a_r5_single_latch: assert property (@(posedge clk) disable iff (!rst_n)
    lat_ev |=> !lat_ev);

  a_r7_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (seg_o == 8'hFF) && (dsel_o == 8'hFF));
endmodule

bind cascade_sipo_latch cascade_sipo_latch_chk #(.W(8), .NS(2)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .out_en (out_en),
  .sh_ev  (sh_ev),
  .lat_ev (lat_ev),
  .ser_s  (ser_s),
  .sr_q   (sr_q),
  .st_q   (st_q),
  .seg_o  (seg_o),
  .dsel_o (dsel_o)
);

// File: tb/cascade_sipo_latch_test.sv
`timescale 1ns/1ps
module cascade_sipo_latch_test;
  logic clk = 1'b0;
  logic rst_n, ser_in, shclk_in, latclk_in, out_en;
  logic [7:0] seg_o, dsel_o;
  logic cascade_o;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cascade_sipo_latch uut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shclk_in(shclk_in),
    .latclk_in(latclk_in), .out_en(out_en), .seg_o(seg_o),
    .dsel_o(dsel_o), .cascade_o(cascade_o)
  );

  localparam int NV = 6;
  localparam logic [15:0] FRAMES [NV] = '{16'h1234, 16'h89AB, 16'hFFFF,
                                          16'h0000, 16'hA55A, 16'h8001};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_in = b; shclk_in = 1'b0; idle(4);
    shclk_in = 1'b1; idle(4);
    shclk_in = 1'b0;
  endtask

  task automatic send_frame(input logic [15:0] f);
    for (int i = 15; i >= 0; i--) send_bit(f[i]);
    idle(4);
  endtask

  task automatic pulse_latch();
    latclk_in = 1'b1; idle(4);
    latclk_in = 1'b0; idle(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] prev;
    rst_n = 1'b0; ser_in = 0; shclk_in = 0; latclk_in = 0; out_en = 1;
    idle(3);
    check("R1 seg in reset", seg_o, 8'hFF);
    check("R1 dsel in reset", dsel_o, 8'hFF);
    rst_n = 1'b1; idle(2);
    check("R1 after release", {cascade_o, seg_o, dsel_o}, {1'b0, 16'hFFFF});

    prev = 16'hFFFF;
    for (int v = 0; v < NV; v++) begin
      send_frame(FRAMES[v]);
      check("R3 no change while shifting", {seg_o, dsel_o}, prev);
      check("R6 cascade equals first bit", cascade_o, FRAMES[v][15]);
      pulse_latch();
      check("R4 seg byte", seg_o, FRAMES[v][15:8]);
      check("R2 R4 dsel byte", dsel_o, FRAMES[v][7:0]);
      prev = FRAMES[v];
    end

    // R5: long high shift clock gives exactly one shift
    send_frame(16'h0000);
    ser_in = 1'b1; idle(4); shclk_in = 1'b1; idle(40); shclk_in = 1'b0; idle(6);
    pulse_latch();
    check("R5 one shift per rise", {seg_o, dsel_o}, 16'h0001);
    latclk_in = 1'b1; idle(30); latclk_in = 1'b0; idle(10);
    check("R5 falling latch no effect", {seg_o, dsel_o}, 16'h0001);

    // R7: blanking keeps stored word
    out_en = 1'b0; idle(2);
    check("R7 blank", {seg_o, dsel_o}, 16'hFFFF);
    out_en = 1'b1; idle(1);
    check("R7 restored", {seg_o, dsel_o}, 16'h0001);

    // R8: latch and shift rise together
    send_frame(16'h3C96);
    ser_in = 1'b1; idle(4);
    shclk_in = 1'b1; latclk_in = 1'b1; idle(4);
    shclk_in = 1'b0; latclk_in = 1'b0; idle(6);
    check("R8 captures pre-shift word", {seg_o, dsel_o}, 16'h3C96);
    pulse_latch();
    check("R8 shift did occur", {seg_o, dsel_o}, 16'h792D);

    // R9: latch latency of three system edges
    send_frame(16'h5AC3);
    latclk_in = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R9 not yet after two edges", {seg_o, dsel_o}, 16'h792D);
    @(posedge clk); @(negedge clk);
    check("R9 updated on third edge", {seg_o, dsel_o}, 16'h5AC3);
    latclk_in = 1'b0; idle(4);

    // R1: reset mid-operation
    rst_n = 1'b0; idle(2);
    check("R1 reset again", {cascade_o, seg_o, dsel_o}, {1'b0, 16'hFFFF});
    rst_n = 1'b1; idle(2);
    pulse_latch();
    check("R1 shift regs cleared", {seg_o, dsel_o}, 16'h0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule